// File: doc/BRIEF.md
# Nonvolatile Shadow Store/Recall Controller

This block places a working RAM and a shadow array that stands in for nonvolatile storage behind one synchronous host port. The host reads and writes the working RAM as a plain single-port memory. On request, or when power is about to go away, the controller copies the working RAM into the shadow array. When power returns, or on request, it copies the shadow array back. Both arrays are inferred memories of parameterised depth.

Each transfer has two phases and walks the whole array, one word per clock. A store first erases the shadow array to all ones and then programs it from the working RAM. A recall first clears the working RAM to zero and then copies the shadow array into it. A fixed settling interval follows each transfer. While a transfer runs, the host port is shut out. A modified flag records whether any host write has landed since the last transfer. A power-loss store is skipped when that flag is clear, so no needless erase/program cycle takes place.

Top module: `nvs_shadow_ctrl`

## Requirements
- R1: `modified` is 0 after reset. It goes to 1 on the clock edge that accepts a host write. It returns to 0 on the edge that ends a store or a recall.
- R2: A falling edge on `pwr_good` while `modified` is 1 starts a store. If `modified` is 0 at that edge, no store starts.
- R3: A pulse on `sw_store` starts a store even when `modified` is 0.
- R4: A store erases every shadow word to all ones, then writes each shadow word with the working-RAM word at the same address. After the store, the shadow array equals the working RAM.
- R5: A recall zeroes every working word, then loads each working word from the shadow word at the same address. The shadow array is left unchanged, so repeated recalls give the same contents.
- R6: While `busy` is 1, host writes are dropped and leave the working RAM unchanged. Host reads return `host_rvalid`=0 and `host_rdata`=0.
- R7: A falling edge on `pwr_good` latches a recall request, and the recall starts once `pwr_good` is high. Reset also latches such a request, so a recall runs after power-up. No latched recall starts while `pwr_good` stays low.
- R8: `busy` rises on the clock edge after a transfer is accepted. It stays high for exactly 2*2^ADDR_W+SETTLE cycles.
- R9: If `sw_store` and `sw_recall` are both high in the same idle cycle, the store runs and the recall request is discarded.
- R10: An idle host read (`host_en`=1, `host_we`=0) returns the addressed word on `host_rdata` with `host_rvalid`=1 one cycle later. `host_rvalid` is 0 when no read was issued.
- R11: `sw_store` and `sw_recall` pulses that arrive while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-valid flag; a falling edge signals power loss |
| sw_store | input | 1 | Software store request, sampled while idle |
| sw_recall | input | 1 | Software recall request, sampled while idle |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data, valid one cycle after the read |
| host_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Store or recall in progress |
| modified | output | 1 | Working RAM written since the last transfer |

## Verification
The assertions check several rules on every cycle. An accepted write sets the modified flag, and finishing a transfer clears it. The program phase can only follow the erase phase, and the copy phase can only follow the clear phase. A power drop with a clean RAM never enters the erase phase. A joint store/recall request always enters the erase phase. No read completes while busy. Other properties can only be shown by the bench's scenarios, because they concern array contents across whole transfers. These are that a store followed by a recall reproduces the stored image, that the shadow array survives repeated recalls, that a power-loss store captures the last write, that dropped writes leave no trace, and that each transfer lasts exactly the expected number of cycles.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG,
        PH_CLEAR,
        PH_COPY,
        PH_SETTLE
    } phase_e;

endpackage

// File: rtl/nvs_mem.sv
module nvs_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[addr] <= wdata;
        end
    end

    assign rdata = cells_q[addr];

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              sw_store,
    input  logic              sw_recall,
    input  logic              host_wr,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              modified
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [ADDR_W-1:0] LAST = '1;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              modified;
        logic              recall_pend;
        logic              auto_pend;
        logic              pg;
    } seq_t;

    seq_t seq_d, seq_q;
    logic pg_fall;

    assign pg_fall = seq_q.pg & ~pwr_good;

    always_comb begin
        seq_d    = seq_q;
        seq_d.pg = pwr_good;
        if (pg_fall) begin
            seq_d.recall_pend = 1'b1;
            if (seq_q.modified) begin
                seq_d.auto_pend = 1'b1;
            end
        end
        if (host_wr) begin
            seq_d.modified = 1'b1;
        end
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (sw_store || seq_d.auto_pend) begin
                    seq_d.phase     = PH_ERASE;
                    seq_d.addr      = '0;
                    seq_d.auto_pend = 1'b0;
                end else if (sw_recall) begin
                    seq_d.phase = PH_CLEAR;
                    seq_d.addr  = '0;
                end else if (seq_q.recall_pend && pwr_good) begin
                    seq_d.phase       = PH_CLEAR;
                    seq_d.addr        = '0;
                    seq_d.recall_pend = 1'b0;
                end
            end
            PH_ERASE: begin
                seq_d.addr = seq_q.addr + 1'b1;
                if (seq_q.addr == LAST) begin
                    seq_d.phase = PH_PROG;
                end
            end
            PH_CLEAR: begin
                seq_d.addr = seq_q.addr + 1'b1;
                if (seq_q.addr == LAST) begin
                    seq_d.phase = PH_COPY;
                end
            end
            PH_PROG, PH_COPY: begin
                seq_d.addr = seq_q.addr + 1'b1;
                if (seq_q.addr == LAST) begin
                    seq_d.phase = PH_SETTLE;
                    seq_d.cnt   = CNT_W'(SETTLE - 1);
                end
            end
            PH_SETTLE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase    = PH_IDLE;
                    seq_d.modified = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q             <= '0;
            seq_q.phase       <= PH_IDLE;
            seq_q.recall_pend <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase    = seq_q.phase;
    assign addr     = seq_q.addr;
    assign busy     = (seq_q.phase != PH_IDLE);
    assign modified = seq_q.modified;

    // R1: accepted write marks the RAM modified
    a_r1_write_sets_modified: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> modified);

    // R1: end of a transfer clears the flag
    a_r1_done_clears_modified: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_SETTLE && seq_q.cnt == '0) |=> !modified);

    // R4: programming only follows erasing
    a_r4_prog_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_PROG && $past(seq_q.phase) != PH_PROG)
            |-> $past(seq_q.phase) == PH_ERASE);

    // R5: copying only follows clearing
    a_r5_copy_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_COPY && $past(seq_q.phase) != PH_COPY)
            |-> $past(seq_q.phase) == PH_CLEAR);

    // R2: power drop with a clean RAM never starts an erase
    a_r2_clean_drop_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_IDLE && pg_fall && !seq_q.modified
            && !seq_q.auto_pend && !sw_store) |=> seq_q.phase != PH_ERASE);

    // R9: joint request resolves to a store
    a_r9_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_IDLE && sw_store && sw_recall) |=> seq_q.phase == PH_ERASE);

endmodule

// File: rtl/nvs_host.sv
module nvs_host #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              host_wr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);
    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t port_d, port_q;

    assign host_wr = host_en & host_we & ~busy;

    always_comb begin
        port_d        = port_q;
        port_d.rvalid = host_en & ~host_we & ~busy;
        port_d.rdata  = port_d.rvalid ? ram_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign host_rdata  = port_q.rdata;
    assign host_rvalid = port_q.rvalid;

    // R6: no read completes from a busy cycle
    a_r6_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !host_rvalid);

    // R6: invalid read cycles carry zero data
    a_r6_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rvalid |-> host_rdata == '0);

endmodule

// File: rtl/nvs_shadow_ctrl.sv
module nvs_shadow_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              sw_store,
    input  logic              sw_recall,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              busy,
    output logic              modified
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    phase_e            phase;
    logic [ADDR_W-1:0] seq_addr;
    logic              host_wr;

    logic              work_we, shd_we;
    logic [ADDR_W-1:0] work_addr;
    logic [DATA_W-1:0] work_wdata, work_rdata;
    logic [DATA_W-1:0] shd_wdata, shd_rdata;

    nvs_seq #(.ADDR_W(ADDR_W), .SETTLE(SETTLE)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .sw_store  (sw_store),
        .sw_recall (sw_recall),
        .host_wr   (host_wr),
        .phase     (phase),
        .addr      (seq_addr),
        .busy      (busy),
        .modified  (modified)
    );

    nvs_host #(.DATA_W(DATA_W)) i_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .host_en     (host_en),
        .host_we     (host_we),
        .ram_rdata   (work_rdata),
        .host_wr     (host_wr),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    always_comb begin
        work_we    = host_wr || phase == PH_CLEAR || phase == PH_COPY;
        work_addr  = busy ? seq_addr : host_addr;
        unique case (phase)
            PH_CLEAR: work_wdata = '0;
            PH_COPY:  work_wdata = shd_rdata;
            default:  work_wdata = host_wdata;
        endcase
        shd_we    = (phase == PH_ERASE) || (phase == PH_PROG);
        shd_wdata = (phase == PH_PROG) ? work_rdata : ERASED;
    end

    nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_work (
        .clk   (clk),
        .we    (work_we),
        .addr  (work_addr),
        .wdata (work_wdata),
        .rdata (work_rdata)
    );

    nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_shadow (
        .clk   (clk),
        .we    (shd_we),
        .addr  (seq_addr),
        .wdata (shd_wdata),
        .rdata (shd_rdata)
    );

    // R6: writes to the working array while busy come only from the sequencer
    a_r6_host_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_wr);

endmodule

// File: tb/test_nvs_shadow_ctrl.sv
module test_nvs_shadow_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int ST = 3;
    localparam int DEPTH = 1 << AW;
    localparam int XFER = 2 * DEPTH + ST;

    // {address, write data}; each entry is written then read back
    localparam logic [15:0] VEC [8] = '{
        16'h00_A5, 16'h0F_3C, 16'h07_00, 16'h08_FF,
        16'h01_5A, 16'h0E_81, 16'h03_C3, 16'h0A_7E
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0;
    logic host_en = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic host_rvalid, busy, modified;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] work_m [DEPTH];
    logic [DW-1:0] shd_m [DEPTH];

    always #2 clk = ~clk;

    nvs_shadow_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETTLE(ST)) i_nvs_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .sw_store(sw_store), .sw_recall(sw_recall),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .busy(busy), .modified(modified)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata; v = host_rvalid;
        host_en = 1'b0;
    endtask

    // counts busy cycles starting at the current negedge
    task automatic run_len(output int n);
        n = 0;
        for (int i = 0; i < 120; i++) begin
            if (busy) n++;
            else if (n > 0) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic st, input logic rc);
        @(negedge clk);
        sw_store = st; sw_recall = rc;
        @(negedge clk);
        sw_store = 1'b0; sw_recall = 1'b0;
    endtask

    task automatic sweep(input string req);
        logic [DW-1:0] d;
        logic v;
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), d, v);
            chk(req, {23'd0, v, d}, {23'd0, 1'b1, shd_m[a]});
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [DW-1:0] d;
        logic v;

        repeat (3) @(negedge clk);
        chk("R1 reset modified", modified, 0);
        chk("R8 reset busy", busy, 0);
        chk("R10 reset rvalid", host_rvalid, 0);

        rst_n = 1'b1;
        @(negedge clk);
        run_len(n);
        chk("R7 power-up recall length", n, XFER);
        chk("R1 clean after recall", modified, 0);

        for (int a = 0; a < DEPTH; a++) begin
            work_m[a] = DW'(a * 29 + 7);
            wr(AW'(a), work_m[a]);
        end
        chk("R1 write sets modified", modified, 1);

        foreach (VEC[i]) begin
            wr(AW'(VEC[i][15:8]), VEC[i][7:0]);
            work_m[VEC[i][15:8]] = VEC[i][7:0];
            rd(AW'(VEC[i][15:8]), d, v);
            chk("R10 read back", {v, d}, {1'b1, VEC[i][7:0]});
        end
        @(negedge clk);
        chk("R10 no read no valid", host_rvalid, 0);

        pulse(1'b1, 1'b0);
        run_len(n);
        chk("R8 store length", n, XFER);
        chk("R1 store clears modified", modified, 0);
        foreach (work_m[a]) shd_m[a] = work_m[a];

        pulse(1'b1, 1'b0);
        chk("R3 clean store runs", busy, 1);
        rd(4'h2, d, v);
        chk("R6 busy read", {v, d}, 9'h000);
        wr(4'h2, 8'hEE);
        run_len(n);
        chk("R6 modified after dropped write", modified, 0);
        rd(4'h2, d, v);
        chk("R6 dropped write", {v, d}, {1'b1, work_m[2]});

        for (int a = 0; a < 4; a++) wr(AW'(a), 8'h11);
        pulse(1'b0, 1'b1);
        run_len(n);
        chk("R8 recall length", n, XFER);
        sweep("R4 R5 recall image");
        wr(4'h5, 8'h99);
        pulse(1'b0, 1'b1);
        run_len(n);
        sweep("R5 shadow unchanged");

        wr(4'h0, 8'hC3);
        pulse(1'b1, 1'b1);
        run_len(n);
        chk("R9 joint length", n, XFER);
        rd(4'h0, d, v);
        chk("R9 store chosen", {v, d}, {1'b1, 8'hC3});
        shd_m[0] = 8'hC3;
        pulse(1'b0, 1'b1);
        run_len(n);
        rd(4'h0, d, v);
        chk("R9 stored value", {v, d}, {1'b1, 8'hC3});

        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        run_len(n);
        repeat (4) @(negedge clk);
        chk("R11 request while busy ignored", busy, 0);

        wr(4'h3, 8'h5A);
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        run_len(n);
        chk("R2 dirty drop stores", n, XFER);
        repeat (5) @(negedge clk);
        chk("R7 recall waits for power", busy, 0);
        pwr_good = 1'b1;
        @(negedge clk);
        run_len(n);
        chk("R7 recall on power return", n, XFER);
        rd(4'h3, d, v);
        chk("R2 last write captured", {v, d}, {1'b1, 8'h5A});

        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        run_len(n);
        chk("R2 clean drop skips store", n, 0);
        pwr_good = 1'b1;
        @(negedge clk);
        run_len(n);
        chk("R7 recall after clean drop", n, XFER);
        rd(4'h3, d, v);
        chk("R5 contents kept", {v, d}, {1'b1, 8'h5A});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule